// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencing Controller

This block sequences the datapath of a small multi-cycle load/store processor. It is a clocked Moore machine with ten states. The opcode of the instruction being executed is its only data input. It drives every datapath select and write strobe for the current cycle. Each instruction walks a path of two to five states that begins at instruction fetch and ends by returning to it. The path depends on the instruction class: load word, store word, register-to-register ALU operation, branch-if-equal or jump.

The control outputs depend on the current state alone, so the opcode may change at any time inside a cycle without disturbing them. The opcode is consulted at only two points. The first is the decode state, which dispatches to a class path. The second is the memory-address state, which splits loads from stores. The opcode patterns for the five classes are module parameters. Any other pattern is treated as unrecognised and sends the machine back to fetch.

Top module: `mc_control_fsm`

## Requirements
- R1: A synchronous, active-high `rst` sampled at a rising edge places the machine in fetch after that edge, from any state. While `rst` is held, fetch is held.
- R2: In fetch the outputs are `pc_wr`=1, `mem_rd`=1, `ir_wr`=1, `alu_b_sel`=01 (constant 4) and all others 0. The next state is always decode.
- R3: In decode only `alu_b_sel`=11 (shifted immediate) is non-zero. The next state is selected by the opcode defaults: 6'b100011 (load) or 6'b101011 (store) go to address compute, 6'b000000 (ALU) goes to execute, 6'b000100 (branch) goes to branch complete and 6'b000010 (jump) goes to jump complete.
- R4: Load path. Address compute (`alu_a_sel`=1, `alu_b_sel`=10) goes to memory read (`addr_sel`=1, `mem_rd`=1), then to load write-back (`wb_sel_mem`=1, `rf_wr`=1), then to fetch.
- R5: Store path. Address compute with the store opcode goes to memory write (`addr_sel`=1, `mem_wr`=1), then to fetch. Address compute with any opcode that is neither load nor store goes to fetch.
- R6: ALU path. Execute (`alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=10) goes to ALU write-back (`rf_wr`=1, `rf_dst_sel`=1), then to fetch.
- R7: Branch complete drives `pc_wr_cond`=1, `pc_src`=01, `alu_op`=01 (subtract), `alu_a_sel`=1 and `alu_b_sel`=00, then goes to fetch.
- R8: Jump complete drives `pc_wr`=1 and `pc_src`=10, then goes to fetch.
- R9: An opcode that matches none of the five classes while in decode returns the machine to fetch.
- R10: The opcode has no effect on the outputs within a cycle. Outside decode and address compute it has no effect on the next state.
- R11: The state register only ever holds one of the ten state codes. `mem_rd` and `mem_wr` are never high together, and `pc_wr` and `pc_wr_cond` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to fetch |
| op | input | OP_W (6) | Opcode field of the current instruction |
| pc_wr | output | 1 | Unconditional program-counter write |
| pc_wr_cond | output | 1 | Program-counter write qualified by the ALU zero flag |
| addr_sel | output | 1 | Memory address from ALU-out register (1) or PC (0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_sel_mem | output | 1 | Register write data from memory data register (1) or ALU-out (0) |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU-out register, 10 jump address |
| alu_op | output | 2 | ALU hint: 00 add, 01 subtract, 10 use function field |
| alu_a_sel | output | 1 | ALU A input: register A (1) or PC (0) |
| alu_b_sel | output | 2 | ALU B input: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register file write strobe |
| rf_dst_sel | output | 1 | Destination register field: rd (1) or rt (0) |

## Verification
The bench walks every path and checks the full output vector of every cycle. Each state has a distinct vector, so a wrong transition shows up as the wrong vector one cycle later. It switches the opcode to a load pattern while in execute; a design that re-decoded outside dispatch would branch into the memory path. It changes the opcode to junk in address compute, which a design with a default-to-write split would turn into a spurious `mem_wr`. It feeds an unrecognised opcode in decode, where a careless default would fall into some class path. It flips the opcode several times inside the branch-complete cycle, so an output that leaked the opcode (a Mealy term) would change between samples. It asserts reset in the middle of a load to prove that reset overrides the remaining path.

// File: rtl/mc_ctrl_pkg.sv
`timescale 1ns/1ps
package mc_ctrl_pkg;

  localparam int unsigned MC_NUM_ST = 10;
  localparam int unsigned MC_ST_W   = $clog2(MC_NUM_ST);

  // State order is fixed: codes 0..9 in path order
  typedef enum logic [MC_ST_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_MRD    = 4'd3,
    ST_MWB    = 4'd4,
    ST_MWR    = 4'd5,
    ST_EXE    = 4'd6,
    ST_AWB    = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } mc_state_e;

  typedef enum logic [2:0] {
    CL_NONE   = 3'd0,
    CL_LOAD   = 3'd1,
    CL_STORE  = 3'd2,
    CL_ALU    = 3'd3,
    CL_BRANCH = 3'd4,
    CL_JUMP   = 3'd5
  } mc_class_e;

  localparam logic [1:0] ALU_ADD   = 2'b00;
  localparam logic [1:0] ALU_SUB   = 2'b01;
  localparam logic [1:0] ALU_FUNCT = 2'b10;

  localparam logic [1:0] BSEL_REG  = 2'b00;
  localparam logic [1:0] BSEL_FOUR = 2'b01;
  localparam logic [1:0] BSEL_IMM  = 2'b10;
  localparam logic [1:0] BSEL_SHL  = 2'b11;

  localparam logic [1:0] PCS_ALU   = 2'b00;
  localparam logic [1:0] PCS_ALUQ  = 2'b01;
  localparam logic [1:0] PCS_JUMP  = 2'b10;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_sel_mem;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       rf_dst_sel;
  } mc_ctrl_t;

  // Transition function: only decode and address compute look at the class
  function automatic mc_state_e mc_next(input mc_state_e s, input mc_class_e c);
    mc_state_e n;
    n = ST_FETCH;
    case (s)
      ST_FETCH:  n = ST_DECODE;
      ST_DECODE: begin
        case (c)
          CL_LOAD, CL_STORE: n = ST_ADDR;
          CL_ALU:            n = ST_EXE;
          CL_BRANCH:         n = ST_BRANCH;
          CL_JUMP:           n = ST_JUMP;
          default:           n = ST_FETCH;
        endcase
      end
      ST_ADDR: begin
        if (c == CL_LOAD)       n = ST_MRD;
        else if (c == CL_STORE) n = ST_MWR;
        else                    n = ST_FETCH;
      end
      ST_MRD:  n = ST_MWB;
      ST_EXE:  n = ST_AWB;
      default: n = ST_FETCH;
    endcase
    return n;
  endfunction

  // Output function: Moore, state only
  function automatic mc_ctrl_t mc_ctrl_of(input mc_state_e s);
    mc_ctrl_t c;
    c = '0;
    case (s)
      ST_FETCH: begin
        c.mem_rd    = 1'b1;
        c.ir_wr     = 1'b1;
        c.pc_wr     = 1'b1;
        c.pc_src    = PCS_ALU;
        c.alu_op    = ALU_ADD;
        c.alu_b_sel = BSEL_FOUR;
      end
      ST_DECODE: begin
        c.alu_op    = ALU_ADD;
        c.alu_b_sel = BSEL_SHL;
      end
      ST_ADDR: begin
        c.alu_a_sel = 1'b1;
        c.alu_b_sel = BSEL_IMM;
        c.alu_op    = ALU_ADD;
      end
      ST_MRD: begin
        c.mem_rd   = 1'b1;
        c.addr_sel = 1'b1;
      end
      ST_MWB: begin
        c.rf_wr      = 1'b1;
        c.wb_sel_mem = 1'b1;
      end
      ST_MWR: begin
        c.mem_wr   = 1'b1;
        c.addr_sel = 1'b1;
      end
      ST_EXE: begin
        c.alu_a_sel = 1'b1;
        c.alu_b_sel = BSEL_REG;
        c.alu_op    = ALU_FUNCT;
      end
      ST_AWB: begin
        c.rf_wr      = 1'b1;
        c.rf_dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        c.alu_a_sel  = 1'b1;
        c.alu_b_sel  = BSEL_REG;
        c.alu_op     = ALU_SUB;
        c.pc_wr_cond = 1'b1;
        c.pc_src     = PCS_ALUQ;
      end
      ST_JUMP: begin
        c.pc_wr  = 1'b1;
        c.pc_src = PCS_JUMP;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mc_op_classify.sv
`timescale 1ns/1ps
module mc_op_classify #(
  parameter int unsigned     OP_W      = 6,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
  parameter logic [OP_W-1:0] OP_ALU    = 6'b000000,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
  input  logic [OP_W-1:0]        op,
  output mc_ctrl_pkg::mc_class_e cls
);
  import mc_ctrl_pkg::*;

  always_comb begin
    if      (op == OP_LOAD)   cls = CL_LOAD;
    else if (op == OP_STORE)  cls = CL_STORE;
    else if (op == OP_ALU)    cls = CL_ALU;
    else if (op == OP_BRANCH) cls = CL_BRANCH;
    else if (op == OP_JUMP)   cls = CL_JUMP;
    else                      cls = CL_NONE;
  end
endmodule

// File: rtl/mc_next_state.sv
`timescale 1ns/1ps
module mc_next_state (
  input  mc_ctrl_pkg::mc_state_e cur,
  input  mc_ctrl_pkg::mc_class_e cls,
  output mc_ctrl_pkg::mc_state_e nxt
);
  import mc_ctrl_pkg::*;

  always_comb nxt = mc_next(cur, cls);
endmodule

// File: rtl/mc_ctrl_out.sv
`timescale 1ns/1ps
module mc_ctrl_out (
  input  mc_ctrl_pkg::mc_state_e cur,
  output mc_ctrl_pkg::mc_ctrl_t  ctl
);
  import mc_ctrl_pkg::*;

  always_comb ctl = mc_ctrl_of(cur);
endmodule

// File: rtl/mc_control_fsm.sv
`timescale 1ns/1ps
module mc_control_fsm #(
  parameter int unsigned     OP_W      = 6,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
  parameter logic [OP_W-1:0] OP_ALU    = 6'b000000,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic            addr_sel,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            ir_wr,
  output logic            wb_sel_mem,
  output logic [1:0]      pc_src,
  output logic [1:0]      alu_op,
  output logic            alu_a_sel,
  output logic [1:0]      alu_b_sel,
  output logic            rf_wr,
  output logic            rf_dst_sel
);
  import mc_ctrl_pkg::*;

  mc_state_e st_q;
  mc_state_e st_d;
  mc_class_e op_cls;
  mc_ctrl_t  ctl;

  mc_op_classify #(
    .OP_W(OP_W), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
    .OP_ALU(OP_ALU), .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
  ) u_cls (
    .op  (op),
    .cls (op_cls)
  );

  mc_next_state u_nxt (
    .cur (st_q),
    .cls (op_cls),
    .nxt (st_d)
  );

  mc_ctrl_out u_out (
    .cur (st_q),
    .ctl (ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_FETCH;
    else     st_q <= st_d;
  end

  assign pc_wr      = ctl.pc_wr;
  assign pc_wr_cond = ctl.pc_wr_cond;
  assign addr_sel   = ctl.addr_sel;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign ir_wr      = ctl.ir_wr;
  assign wb_sel_mem = ctl.wb_sel_mem;
  assign pc_src     = ctl.pc_src;
  assign alu_op     = ctl.alu_op;
  assign alu_a_sel  = ctl.alu_a_sel;
  assign alu_b_sel  = ctl.alu_b_sel;
  assign rf_wr      = ctl.rf_wr;
  assign rf_dst_sel = ctl.rf_dst_sel;
endmodule

// File: rtl/mc_control_fsm_chk.sv
`timescale 1ns/1ps
module mc_control_fsm_chk #(
  parameter int unsigned     OP_W      = 6,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
  parameter logic [OP_W-1:0] OP_ALU    = 6'b000000,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] op,
  input logic [3:0]      st,
  input logic            pc_wr,
  input logic            pc_wr_cond,
  input logic            mem_rd,
  input logic            mem_wr
);
  import mc_ctrl_pkg::*;

  logic is_ld, is_sd, is_al, is_br, is_jp, is_none;
  assign is_ld   = (op == OP_LOAD);
  assign is_sd   = (op == OP_STORE);
  assign is_al   = (op == OP_ALU);
  assign is_br   = (op == OP_BRANCH);
  assign is_jp   = (op == OP_JUMP);
  assign is_none = !(is_ld || is_sd || is_al || is_br || is_jp);

  assert_reset_fetch_R1: assert property (@(posedge clk)
    rst |=> (st == ST_FETCH));

  assert_fetch_decode_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FETCH) |=> (st == ST_DECODE));

  assert_dispatch_mem_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE && (is_ld || is_sd)) |=> (st == ST_ADDR));
  assert_dispatch_alu_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE && is_al) |=> (st == ST_EXE));
  assert_dispatch_br_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE && is_br) |=> (st == ST_BRANCH));
  assert_dispatch_jp_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE && is_jp) |=> (st == ST_JUMP));

  assert_addr_load_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADDR && is_ld) |=> (st == ST_MRD));
  assert_mrd_mwb_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MRD) |=> (st == ST_MWB));
  assert_mwb_fetch_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MWB) |=> (st == ST_FETCH));

  assert_addr_store_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADDR && is_sd) |=> (st == ST_MWR));
  assert_addr_other_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADDR && !is_ld && !is_sd) |=> (st == ST_FETCH));
  assert_mwr_fetch_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MWR) |=> (st == ST_FETCH));

  assert_exe_awb_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXE) |=> (st == ST_AWB));
  assert_awb_fetch_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_AWB) |=> (st == ST_FETCH));

  assert_branch_fetch_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BRANCH) |=> (st == ST_FETCH));
  assert_cond_only_branch_R7: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |-> (st == ST_BRANCH));

  assert_jump_fetch_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_JUMP) |=> (st == ST_FETCH));

  assert_unknown_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE && is_none) |=> (st == ST_FETCH));

  assert_legal_state_R11: assert property (@(posedge clk) disable iff (rst)
    (st <= 4'd9));
  assert_mem_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  assert_pc_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(pc_wr && pc_wr_cond));
endmodule

bind mc_control_fsm mc_control_fsm_chk #(
  .OP_W(OP_W), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
  .OP_ALU(OP_ALU), .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op         (op),
  .st         (st_q),
  .pc_wr      (pc_wr),
  .pc_wr_cond (pc_wr_cond),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr)
);

// File: tb/test_mc_control_fsm.sv
`timescale 1ns/1ps
module test_mc_control_fsm;
  localparam logic [5:0] K_LD  = 6'b100011;
  localparam logic [5:0] K_SD  = 6'b101011;
  localparam logic [5:0] K_AL  = 6'b000000;
  localparam logic [5:0] K_BR  = 6'b000100;
  localparam logic [5:0] K_JP  = 6'b000010;
  localparam logic [5:0] K_BAD = 6'b111111;

  localparam int P_F = 0, P_D = 1, P_A = 2, P_MR = 3, P_LW = 4,
                 P_MW = 5, P_X = 6, P_XW = 7, P_B = 8, P_J = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] op = 6'b0;
  logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel_mem;
  logic [1:0] pc_src, alu_op, alu_b_sel;
  logic alu_a_sel, rf_wr, rf_dst_sel;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [15:0] qv[$];
  string       qt[$];

  always #2 clk = ~clk;

  mc_control_fsm i_mc_control_fsm (
    .clk(clk), .rst(rst), .op(op),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_sel_mem(wb_sel_mem),
    .pc_src(pc_src), .alu_op(alu_op), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel)
  );

  function automatic logic [15:0] seen();
    return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel_mem,
            pc_src, alu_op, alu_a_sel, alu_b_sel, rf_wr, rf_dst_sel};
  endfunction

  // Expected control vector per state, taken from the requirement text
  function automatic logic [15:0] want(input int s);
    logic pw = 0, pwc = 0, asl = 0, mr = 0, mw = 0, iw = 0, wm = 0;
    logic aa = 0, rw = 0, rd = 0;
    logic [1:0] ps = 2'b00, ao = 2'b00, bs = 2'b00;
    case (s)
      P_F:  begin pw = 1; mr = 1; iw = 1; bs = 2'b01; end
      P_D:  begin bs = 2'b11; end
      P_A:  begin aa = 1; bs = 2'b10; end
      P_MR: begin asl = 1; mr = 1; end
      P_LW: begin wm = 1; rw = 1; end
      P_MW: begin asl = 1; mw = 1; end
      P_X:  begin aa = 1; ao = 2'b10; end
      P_XW: begin rw = 1; rd = 1; end
      P_B:  begin pwc = 1; ps = 2'b01; ao = 2'b01; aa = 1; end
      P_J:  begin pw = 1; ps = 2'b10; end
      default: ;
    endcase
    return {pw, pwc, asl, mr, mw, iw, wm, ps, ao, aa, bs, rw, rd};
  endfunction

  // Driver step: enter next cycle, queue its expected vector
  task automatic cyc(input int s, input string tag);
    @(posedge clk);
    #0.5;
    qv.push_back(want(s));
    qt.push_back(tag);
  endtask

  // Monitor: pops and compares in the middle of each cycle
  always @(negedge clk) begin
    if (qv.size() > 0) begin
      logic [15:0] e;
      string t;
      e = qv.pop_front();
      t = qt.pop_front();
      total++;
      if (seen() !== e) begin
        bad++;
        $display("FAIL %s: got %h expected %h", t, seen(), e);
      end
    end
  end

  // Opcode flips inside one cycle must leave the outputs alone (R10)
  task automatic flip_check();
    logic [15:0] v0;
    v0 = seen();
    for (int k = 0; k < 3; k++) begin
      op = (k == 0) ? K_LD : (k == 1) ? K_BAD : K_SD;
      #0.3;
      total++;
      if (seen() !== v0) begin
        bad++;
        $display("FAIL R10: got %h expected %h", seen(), v0);
      end
    end
  endtask

  // Each run_* starts in a fetch cycle and ends in one
  task automatic run_load();
    op = K_LD;
    cyc(P_D, "R2"); cyc(P_A, "R3"); cyc(P_MR, "R4"); cyc(P_LW, "R4");
    cyc(P_F, "R4");
  endtask

  task automatic run_store();
    op = K_SD;
    cyc(P_D, "R2"); cyc(P_A, "R3"); cyc(P_MW, "R5"); cyc(P_F, "R5");
  endtask

  initial begin
    // R1: reset held, fetch vector
    cyc(P_F, "R1");
    cyc(P_F, "R1");
    rst = 1'b0;
    run_load();
    run_store();
    // R6 ALU path
    op = K_AL;
    cyc(P_D, "R2"); cyc(P_X, "R3"); cyc(P_XW, "R6"); cyc(P_F, "R6");
    // R7 branch, with in-cycle opcode flips (R10)
    op = K_BR;
    cyc(P_D, "R2"); cyc(P_B, "R3");
    flip_check();
    cyc(P_F, "R7");
    // R8 jump
    op = K_JP;
    cyc(P_D, "R2"); cyc(P_J, "R3"); cyc(P_F, "R8");
    // R9 unrecognised opcode
    op = K_BAD;
    cyc(P_D, "R2"); cyc(P_F, "R9");
    // R10 opcode changed to load during execute
    op = K_AL;
    cyc(P_D, "R2"); cyc(P_X, "R3");
    op = K_LD;
    cyc(P_XW, "R10"); cyc(P_F, "R10");
    // R5 store opcode replaced by junk in address compute
    op = K_SD;
    cyc(P_D, "R2"); cyc(P_A, "R3");
    op = K_BAD;
    cyc(P_F, "R5");
    // R1 reset in the middle of a load
    op = K_LD;
    cyc(P_D, "R2"); cyc(P_A, "R3"); cyc(P_MR, "R4");
    rst = 1'b1;
    cyc(P_F, "R1");
    rst = 1'b0;
    // back-to-back loads, then store, then jump
    run_load();
    run_load();
    run_store();
    op = K_JP;
    cyc(P_D, "R2"); cyc(P_J, "R8"); cyc(P_F, "R8");
    @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule